// File: doc/BRIEF.md
# Banked Two-Port Synchronous Memory

This block is a two-port synchronous memory whose storage is split into a parameterised number of independent banks of 18-bit words. Each port has its own two-level chip select, read/write select, a pair of active-low byte-lane enables, an asynchronous output enable, a bank address and a word address. Either port may use any bank, provided the other port is not using the same bank in that cycle. When both selected ports name the same bank, both accesses are voided rather than arbitrated, and each port raises a collision flag.

Each port picks its own read latency. In flow-through mode, read data is driven in the cycle after the address is captured. In pipelined mode it is driven one cycle later, which leaves a full cycle of timing slack after the array. Read data leaves on a separate output bus with a per-lane drive-enable vector. A lane whose drive-enable is low stands for a high-impedance lane and reads as zero. Both ports share one clock.

Top module: `bankdp_mem`

## Requirements
- R1: A port is selected only while its `cs0_n` is 0 and its `cs1` is 1. A deselected port writes nothing, drives no lane in its read data slot, and never raises its collision flag.
- R2: `read`=1 requests a read and `read`=0 requests a write. Control, address and write data are captured on the rising clock edge. A word written at one edge is returned by a read captured at the next edge.
- R3: With `flow`=1, read data and its lane drive-enables appear in the cycle that follows the capturing edge.
- R4: With `flow`=0, read data appears one cycle later than in flow-through mode. In the slot between, the port shows the result of its previous cycle, which is undriven (`rdrv`=0) after an idle cycle.
- R5: `be_n[0]` governs bits 8:0 and `be_n[1]` governs bits 17:9, both active low. A write leaves the bits of a disabled lane unchanged. A read drives only the enabled lanes (`rdrv[0]` for bits 8:0, `rdrv[1]` for bits 17:9), and an undriven lane reads as 0.
- R6: `oe_n`=1 forces `rdrv` and `rdata` to zero at once, without waiting for a clock edge. Clearing `oe_n` restores the held read data at once.
- R7: Either port can read and write every bank. Two selected ports on different banks in the same cycle both complete.
- R8: When both ports are selected with equal bank addresses, neither port writes. A read on either port returns 18'h3FFFF on its enabled lanes. Each port raises `clash` in its own read data slot, whose timing depends on that port's mode.
- R9: A collision needs both ports selected. A selected port sharing a bank address with a deselected port completes normally, with no flag.
- R10: After reset, `rdrv`, `rdata` and `clash` are 0 on both ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Active-low reset of the output pipelines |
| a_cs0_n | input | 1 | Port A select, active low |
| a_cs1 | input | 1 | Port A select, active high |
| a_read | input | 1 | Port A: 1 read, 0 write |
| a_be_n | input | 2 | Port A byte-lane enables, active low |
| a_oe_n | input | 1 | Port A asynchronous output enable, active low |
| a_flow | input | 1 | Port A: 1 flow-through, 0 pipelined |
| a_bank | input | BANK_W | Port A bank address |
| a_word | input | WORD_W | Port A word address within the bank |
| a_wdata | input | 18 | Port A write data |
| a_rdata | output | 18 | Port A read data |
| a_rdrv | output | 2 | Port A per-lane drive-enables |
| a_clash | output | 1 | Port A collision flag |
| b_cs0_n | input | 1 | Port B select, active low |
| b_cs1 | input | 1 | Port B select, active high |
| b_read | input | 1 | Port B: 1 read, 0 write |
| b_be_n | input | 2 | Port B byte-lane enables, active low |
| b_oe_n | input | 1 | Port B asynchronous output enable, active low |
| b_flow | input | 1 | Port B: 1 flow-through, 0 pipelined |
| b_bank | input | BANK_W | Port B bank address |
| b_word | input | WORD_W | Port B word address within the bank |
| b_wdata | input | 18 | Port B write data |
| b_rdata | output | 18 | Port B read data |
| b_rdrv | output | 2 | Port B per-lane drive-enables |
| b_clash | output | 1 | Port B collision flag |

## Verification
The assertions assume that every control, address and data input is driven to a known level from the first clock edge onward. They also assume that a port's `flow` input changes only when that port has been idle for two cycles, so that a slot never mixes the two latencies. The stimulus drives every input one half period away from the capturing edge and sets `flow` only between idle stretches. It also never reads a word before writing it, so no uninitialised array content reaches a comparison.

// File: rtl/bdp_pkg.sv
package bdp_pkg;
    localparam int unsigned DATA_W = 18;
    localparam int unsigned LANE_W = 9;
    localparam int unsigned LANES  = DATA_W / LANE_W;

    localparam logic [DATA_W-1:0] VOID_WORD = '1;

    typedef struct packed {
        logic [LANES-1:0]  drv;
        logic [DATA_W-1:0] data;
        logic              clash;
    } rd_stage_t;

    typedef struct packed {
        rd_stage_t s1;
        rd_stage_t s2;
    } out_pipe_t;
endpackage

// File: rtl/bdp_clash.sv
module bdp_clash #(
    parameter int unsigned BANK_W = 3
) (
    input  logic              a_sel,
    input  logic              b_sel,
    input  logic [BANK_W-1:0] a_bank,
    input  logic [BANK_W-1:0] b_bank,
    output logic              clash
);
    always_comb begin
        clash = a_sel && b_sel && (a_bank == b_bank);
    end
endmodule

// File: rtl/bdp_bank.sv
module bdp_bank
    import bdp_pkg::*;
#(
    parameter int unsigned DEPTH  = 64,
    parameter int unsigned WORD_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_we,
    input  logic [LANES-1:0]  a_lane,
    input  logic [WORD_W-1:0] a_word,
    input  logic [DATA_W-1:0] a_wdata,
    input  logic              b_we,
    input  logic [LANES-1:0]  b_lane,
    input  logic [WORD_W-1:0] b_word,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] a_rword,
    output logic [DATA_W-1:0] b_rword
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        for (int l = 0; l < LANES; l++) begin
            if (a_we && a_lane[l]) begin
                mem_q[a_word][l*LANE_W +: LANE_W] <= a_wdata[l*LANE_W +: LANE_W];
            end else if (b_we && b_lane[l]) begin
                mem_q[b_word][l*LANE_W +: LANE_W] <= b_wdata[l*LANE_W +: LANE_W];
            end
        end
    end

    always_comb begin
        a_rword = mem_q[a_word];
        b_rword = mem_q[b_word];
    end

    // R8
    single_writer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({a_we, b_we}));
endmodule

// File: rtl/bdp_port_out.sv
module bdp_port_out
    import bdp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flow,
    input  logic              oe_n,
    input  logic              sel,
    input  logic              rd,
    input  logic [LANES-1:0]  lane_en,
    input  logic              clash,
    input  logic [DATA_W-1:0] rword,
    output logic [DATA_W-1:0] rdata,
    output logic [LANES-1:0]  rdrv,
    output logic              clash_o
);
    out_pipe_t pipe_d, pipe_q;
    rd_stage_t slot;

    always_comb begin
        pipe_d          = pipe_q;
        pipe_d.s1.drv   = (sel && rd) ? lane_en : '0;
        pipe_d.s1.data  = clash ? VOID_WORD : rword;
        pipe_d.s1.clash = clash;
        pipe_d.s2       = pipe_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    always_comb begin
        slot    = flow ? pipe_q.s1 : pipe_q.s2;
        rdrv    = oe_n ? '0 : slot.drv;
        clash_o = slot.clash;
        for (int l = 0; l < LANES; l++) begin
            rdata[l*LANE_W +: LANE_W] = rdrv[l] ? slot.data[l*LANE_W +: LANE_W] : '0;
        end
    end

    // R1
    idle_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sel) |-> !pipe_q.s1.clash);

    // R3
    flow_idle_undriven_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flow && $past(flow) && !$past(sel) |-> rdrv == '0);
endmodule

// File: rtl/bankdp_mem.sv
module bankdp_mem
    import bdp_pkg::*;
#(
    parameter int unsigned NUM_BANKS  = 8,
    parameter int unsigned BANK_DEPTH = 64,
    localparam int unsigned BANK_W    = $clog2(NUM_BANKS),
    localparam int unsigned WORD_W    = $clog2(BANK_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_cs0_n,
    input  logic              a_cs1,
    input  logic              a_read,
    input  logic [1:0]        a_be_n,
    input  logic              a_oe_n,
    input  logic              a_flow,
    input  logic [BANK_W-1:0] a_bank,
    input  logic [WORD_W-1:0] a_word,
    input  logic [17:0]       a_wdata,
    output logic [17:0]       a_rdata,
    output logic [1:0]        a_rdrv,
    output logic              a_clash,
    input  logic              b_cs0_n,
    input  logic              b_cs1,
    input  logic              b_read,
    input  logic [1:0]        b_be_n,
    input  logic              b_oe_n,
    input  logic              b_flow,
    input  logic [BANK_W-1:0] b_bank,
    input  logic [WORD_W-1:0] b_word,
    input  logic [17:0]       b_wdata,
    output logic [17:0]       b_rdata,
    output logic [1:0]        b_rdrv,
    output logic              b_clash
);
    logic              a_sel, b_sel, collide;
    logic              a_wr_go, b_wr_go;
    logic [LANES-1:0]  a_lane, b_lane;
    logic [NUM_BANKS-1:0] a_we_vec, b_we_vec;
    logic [DATA_W-1:0] a_bank_rd [NUM_BANKS];
    logic [DATA_W-1:0] b_bank_rd [NUM_BANKS];
    logic [DATA_W-1:0] a_rword, b_rword;

    always_comb begin
        a_sel   = !a_cs0_n && a_cs1;
        b_sel   = !b_cs0_n && b_cs1;
        a_lane  = ~a_be_n;
        b_lane  = ~b_be_n;
        a_wr_go = a_sel && !a_read && !collide;
        b_wr_go = b_sel && !b_read && !collide;
        a_rword = a_bank_rd[a_bank];
        b_rword = b_bank_rd[b_bank];
    end

    bdp_clash #(.BANK_W(BANK_W)) u_clash (
        .a_sel  (a_sel),
        .b_sel  (b_sel),
        .a_bank (a_bank),
        .b_bank (b_bank),
        .clash  (collide)
    );

    for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
        assign a_we_vec[i] = a_wr_go && (a_bank == BANK_W'(i));
        assign b_we_vec[i] = b_wr_go && (b_bank == BANK_W'(i));

        bdp_bank #(.DEPTH(BANK_DEPTH), .WORD_W(WORD_W)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .a_we    (a_we_vec[i]),
            .a_lane  (a_lane),
            .a_word  (a_word),
            .a_wdata (a_wdata),
            .b_we    (b_we_vec[i]),
            .b_lane  (b_lane),
            .b_word  (b_word),
            .b_wdata (b_wdata),
            .a_rword (a_bank_rd[i]),
            .b_rword (b_bank_rd[i])
        );
    end

    bdp_port_out u_out_a (
        .clk     (clk),
        .rst_n   (rst_n),
        .flow    (a_flow),
        .oe_n    (a_oe_n),
        .sel     (a_sel),
        .rd      (a_read),
        .lane_en (a_lane),
        .clash   (collide),
        .rword   (a_rword),
        .rdata   (a_rdata),
        .rdrv    (a_rdrv),
        .clash_o (a_clash)
    );

    bdp_port_out u_out_b (
        .clk     (clk),
        .rst_n   (rst_n),
        .flow    (b_flow),
        .oe_n    (b_oe_n),
        .sel     (b_sel),
        .rd      (b_read),
        .lane_en (b_lane),
        .clash   (collide),
        .rword   (b_rword),
        .rdata   (b_rdata),
        .rdrv    (b_rdrv),
        .clash_o (b_clash)
    );

    // R8
    void_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        collide |-> !(|a_we_vec) && !(|b_we_vec));

    // R9
    lone_port_no_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_sel && b_sel) |-> !collide);
endmodule

// File: tb/bankdp_mem_tb.sv
module bankdp_mem_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 4;
    localparam int ND = 16;
    localparam int BW = $clog2(NB);
    localparam int WW = $clog2(ND);

    logic clk = 0;
    logic rst_n = 0;
    logic a_cs0_n = 1, a_cs1 = 0, a_read = 1, a_oe_n = 0, a_flow = 1;
    logic b_cs0_n = 1, b_cs1 = 0, b_read = 1, b_oe_n = 0, b_flow = 1;
    logic [1:0] a_be_n = 2'b00, b_be_n = 2'b00;
    logic [BW-1:0] a_bank = '0, b_bank = '0;
    logic [WW-1:0] a_word = '0, b_word = '0;
    logic [17:0] a_wdata = '0, b_wdata = '0;
    logic [17:0] a_rdata, b_rdata;
    logic [1:0] a_rdrv, b_rdrv;
    logic a_clash, b_clash;

    int total = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bankdp_mem #(.NUM_BANKS(NB), .BANK_DEPTH(ND)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .a_cs0_n(a_cs0_n), .a_cs1(a_cs1), .a_read(a_read), .a_be_n(a_be_n),
        .a_oe_n(a_oe_n), .a_flow(a_flow), .a_bank(a_bank), .a_word(a_word),
        .a_wdata(a_wdata), .a_rdata(a_rdata), .a_rdrv(a_rdrv), .a_clash(a_clash),
        .b_cs0_n(b_cs0_n), .b_cs1(b_cs1), .b_read(b_read), .b_be_n(b_be_n),
        .b_oe_n(b_oe_n), .b_flow(b_flow), .b_bank(b_bank), .b_word(b_word),
        .b_wdata(b_wdata), .b_rdata(b_rdata), .b_rdrv(b_rdrv), .b_clash(b_clash)
    );

    function automatic logic [17:0] pat(input int idx, input int salt);
        pat = 18'((idx * 2731 + salt * 977 + 341) % 262144);
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_a(input logic sel, input logic rd, input logic [1:0] be_n,
                         input int bank, input int word, input logic [17:0] wd);
        a_cs0_n = !sel; a_cs1 = sel; a_read = rd; a_be_n = be_n;
        a_bank = BW'(bank); a_word = WW'(word); a_wdata = wd;
    endtask

    task automatic set_b(input logic sel, input logic rd, input logic [1:0] be_n,
                         input int bank, input int word, input logic [17:0] wd);
        b_cs0_n = !sel; b_cs1 = sel; b_read = rd; b_be_n = be_n;
        b_bank = BW'(bank); b_word = WW'(word); b_wdata = wd;
    endtask

    task automatic idle_both();
        set_a(0, 1, 2'b00, 0, 0, '0);
        set_b(0, 1, 2'b00, 0, 0, '0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++; total++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10", "a_rdrv", a_rdrv, 0);
        chk("R10", "b_rdrv", b_rdrv, 0);
        chk("R10", "a_clash", a_clash, 0);
        chk("R10", "b_rdata", b_rdata, 0);
        rst_n = 1;
        step();

        // R2 R7: port A fills every word of every bank
        for (int i = 0; i < NB*ND; i++) begin
            set_a(1, 0, 2'b00, i / ND, i % ND, pat(i, 0));
            step();
        end
        idle_both();
        step();
        // R3 R7: port B reads everything back in flow-through mode
        for (int i = 0; i < NB*ND; i++) begin
            set_b(1, 1, 2'b00, i / ND, i % ND, '0);
            step();
            chk("R3", "b_rdata", b_rdata, pat(i, 0));
            chk("R3", "b_rdrv", b_rdrv, 3);
            chk("R9", "b_clash", b_clash, 0);
        end
        idle_both();
        step();

        // R4: pipelined read on port A over all banks
        a_flow = 0;
        step();
        for (int k = 0; k < NB; k++) begin
            set_a(1, 1, 2'b00, k, 3, '0);
            step();
            idle_both();
            chk("R4", "a_rdrv early", a_rdrv, 0);
            step();
            chk("R4", "a_rdata late", a_rdata, pat(k*ND + 3, 0));
            chk("R4", "a_rdrv late", a_rdrv, 3);
            step();
        end
        a_flow = 1;
        step();

        // R5: lane-limited writes keep the other lane
        set_a(1, 0, 2'b10, 2, 5, 18'h3FFFF);
        step();
        set_a(1, 0, 2'b01, 1, 7, 18'h3FFFF);
        step();
        set_a(1, 1, 2'b00, 2, 5, '0);
        step();
        chk("R5", "lower lane write", a_rdata,
            int'({pat(2*ND+5, 0)[17:9], 9'h1FF}));
        set_a(1, 1, 2'b00, 1, 7, '0);
        step();
        chk("R5", "upper lane write", a_rdata,
            int'({9'h1FF, pat(1*ND+7, 0)[8:0]}));
        set_a(1, 1, 2'b01, 0, 9, '0);
        step();
        chk("R5", "upper-only read rdrv", a_rdrv, 2);
        chk("R5", "upper-only read data", a_rdata, int'({pat(9, 0)[17:9], 9'h000}));
        set_a(1, 1, 2'b10, 0, 9, '0);
        step();
        chk("R5", "lower-only read data", a_rdata, int'({9'h000, pat(9, 0)[8:0]}));

        // R6: asynchronous output enable
        set_a(1, 1, 2'b00, 3, 2, '0);
        step();
        idle_both();
        a_oe_n = 1;
        #1;
        chk("R6", "rdrv with oe off", a_rdrv, 0);
        chk("R6", "rdata with oe off", a_rdata, 0);
        a_oe_n = 0;
        #1;
        chk("R6", "rdata with oe on", a_rdata, pat(3*ND+2, 0));
        step();

        // R1: deselect by either select line
        a_cs0_n = 0; a_cs1 = 0; a_read = 0; a_be_n = 2'b00;
        a_bank = 2'd3; a_word = 4'd4; a_wdata = 18'h0;
        step();
        a_cs0_n = 1; a_cs1 = 1; a_read = 1;
        step();
        chk("R1", "deselected read rdrv", a_rdrv, 0);
        set_a(1, 1, 2'b00, 3, 4, '0);
        step();
        chk("R1", "deselected write ignored", a_rdata, pat(3*ND+4, 0));

        // R7: both ports write different banks in one cycle, then cross read
        set_a(1, 0, 2'b00, 0, 1, pat(1, 5));
        set_b(1, 0, 2'b00, 3, 1, pat(3*ND+1, 5));
        step();
        set_a(1, 1, 2'b00, 3, 1, '0);
        set_b(1, 1, 2'b00, 0, 1, '0);
        step();
        chk("R7", "a cross read", a_rdata, pat(3*ND+1, 5));
        chk("R7", "b cross read", b_rdata, pat(1, 5));
        chk("R7", "no clash", a_clash | b_clash, 0);

        // R9: same bank with one port deselected
        set_a(1, 0, 2'b00, 1, 2, pat(ND+2, 6));
        set_b(0, 1, 2'b00, 1, 2, '0);
        step();
        chk("R9", "no clash lone port", a_clash, 0);
        set_a(1, 1, 2'b00, 1, 2, '0);
        idle_both();
        set_a(1, 1, 2'b00, 1, 2, '0);
        step();
        chk("R9", "lone write landed", a_rdata, pat(ND+2, 6));

        // R8: colliding writes on every bank are both dropped
        for (int k = 0; k < NB; k++) begin
            set_a(1, 0, 2'b00, k, 11, 18'h0);
            set_b(1, 0, 2'b00, k, 12, 18'h0);
            step();
            chk("R8", "a flag write clash", a_clash, 1);
            chk("R8", "b flag write clash", b_clash, 1);
            set_a(1, 1, 2'b00, k, 11, '0);
            set_b(0, 1, 2'b00, 0, 0, '0);
            step();
            chk("R8", "a word kept", a_rdata, pat(k*ND+11, 0));
            set_a(1, 1, 2'b00, k, 12, '0);
            step();
            chk("R8", "b word kept", a_rdata, pat(k*ND+12, 0));
        end
        idle_both();
        step();
        step();

        // R8: colliding reads, port A pipelined, port B flow-through
        a_flow = 0;
        step();
        set_a(1, 1, 2'b00, 2, 0, '0);
        set_b(1, 1, 2'b01, 2, 1, '0);
        step();
        idle_both();
        chk("R8", "b flag in its slot", b_clash, 1);
        chk("R8", "b void data", b_rdata, int'({9'h1FF, 9'h000}));
        chk("R8", "a flag not yet", a_clash, 0);
        step();
        chk("R8", "a flag late", a_clash, 1);
        chk("R8", "a void data", a_rdata, 18'h3FFFF);
        chk("R8", "b flag cleared", b_clash, 0);
        step();
        a_flow = 1;
        step();

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule